// File: doc/BRIEF.md
# Call Target Membership Checker

This unit decides whether a pointer may be used as the target of an indirect call. Each request carries the candidate pointer and a region description. The region description is a base address, an alignment exponent and a size counted in aligned slots. The request also carries a 64-bit membership vector, a 2-bit check mode and a fallback address. The unit subtracts the base from the pointer. It then rotates the difference right by the alignment exponent. Any misaligned low bits end up in the top of the word. A single unsigned compare against the slot count therefore rejects both out-of-range and misaligned pointers.

The mode picks how membership is decided after the bounds step. In the vector mode, the slot index selects a bit of the vector. In the all-ones mode, the vector is bypassed. In the equality mode, the pointer must equal the single permitted address. A check that fails either traps or redirects to the fallback address, depending on whether that address is zero. Requests arrive over a valid/ready handshake. The verdict is registered and appears one cycle after acceptance. Only one request is outstanding at a time.

Top module: `call_target_checker`

## Requirements
- R1: After reset, rsp_valid, rsp_pass and rsp_trap are 0, rsp_redirect is 0 and req_ready is 1.
- R2: A request accepted at a clock edge (req_valid and req_ready both 1) produces rsp_valid = 1 for exactly the following cycle. req_ready is 0 during that cycle, so no second request is accepted in it. With no accepted request, rsp_valid stays 0.
- R3: The bounds test passes only when the slot index is below req_size. The slot index is (req_ptr - req_base) modulo 2^32, rotated right by req_align bits. A pointer below the base, or at or beyond base + (req_size << req_align), fails. A req_size of 0 always fails. This holds when req_size << req_align is below 2^32 and req_align <= 12.
- R4: A pointer whose offset from the base has any of its low req_align bits set fails the bounds test.
- R5: In mode 2'd0 (vector), the pointer passes when it is in bounds and bit [slot index] of req_vec is 1. A slot index of 64 or more fails.
- R6: In mode 2'd1 (all-ones), the pointer passes whenever it is in bounds, whatever req_vec holds.
- R7: In mode 2'd2 (equality), the pointer passes exactly when req_ptr equals req_base. req_size, req_align and req_vec have no effect in this mode.
- R8: In mode 2'd3, the check always fails.
- R9: On a failed check with req_fail_tgt = 0, the response has rsp_trap = 1, rsp_pass = 0 and rsp_redirect = 0.
- R10: On a failed check with a nonzero req_fail_tgt, the response has rsp_trap = 0, rsp_pass = 0 and rsp_redirect equal to req_fail_tgt.
- R11: On a passed check, the response has rsp_pass = 1, rsp_trap = 0 and rsp_redirect equal to the checked pointer.
- R12: rsp_pass, rsp_trap and rsp_redirect keep their last values until the next accepted request updates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_ptr | input | PTR_W | Candidate call target |
| req_base | input | PTR_W | Region base, or the single permitted address in equality mode |
| req_align | input | ALIGN_W | Alignment exponent |
| req_size | input | SIZE_W | Region size in aligned slots |
| req_vec | input | VEC_W | Membership vector, one bit per slot |
| req_mode | input | 2 | 0 vector, 1 all-ones, 2 equality, 3 deny |
| req_fail_tgt | input | PTR_W | Fallback address; zero selects a trap |
| rsp_valid | output | 1 | Verdict valid this cycle |
| rsp_pass | output | 1 | Pointer accepted |
| rsp_trap | output | 1 | Failure with trap |
| rsp_redirect | output | PTR_W | Pointer on pass, fallback on redirect, 0 on trap |

## Verification
An aligned region is probed in several places: the first slot, the last slot, one slot past the end, below the base and at a misaligned offset. Together these show that the merged rotate-and-compare separates in-range, out-of-range and misaligned pointers. The same offsets are replayed under a sparse vector and under a range larger than the vector. This tells the vector test apart from the all-ones bypass and shows how out-of-vector slots are rejected. Equality mode is tried with a zero size, which shows that its bounds inputs are ignored. Each failure is run with both a zero and a nonzero fallback, which separates trap from redirect. Idle cycles between requests show that the verdict is held.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
    typedef enum logic [1:0] {
        MODE_VECTOR  = 2'd0,
        MODE_ALLONES = 2'd1,
        MODE_EQUAL   = 2'd2,
        MODE_DENY    = 2'd3
    } chk_mode_e;
endpackage

// File: rtl/cfc_bounds.sv
module cfc_bounds #(
    parameter int PTR_W   = 32,
    parameter int ALIGN_W = 4,
    parameter int SIZE_W  = 20
) (
    input  logic [PTR_W-1:0]   ptr,
    input  logic [PTR_W-1:0]   base,
    input  logic [ALIGN_W-1:0] align,
    input  logic [SIZE_W-1:0]  size,
    output logic [PTR_W-1:0]   slot,
    output logic               in_bounds
);
    localparam int PAD_W = PTR_W - SIZE_W;

    logic [PTR_W-1:0]   offset;
    logic [2*PTR_W-1:0] doubled;
    logic [PTR_W-1:0]   size_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign size_ext = {{PAD_W{1'b0}}, size};
        end else begin : g_nopad
            assign size_ext = size[PTR_W-1:0];
        end
    endgenerate

    always_comb begin
        offset    = ptr - base;
        // rotate right: misaligned low bits wrap into the top of the word
        doubled   = {offset, offset} >> align;
        slot      = doubled[PTR_W-1:0];
        in_bounds = slot < size_ext;
    end
endmodule

// File: rtl/cfc_membership.sv
module cfc_membership
    import cfc_pkg::*;
#(
    parameter int PTR_W = 32,
    parameter int VEC_W = 64
) (
    input  chk_mode_e        mode,
    input  logic             in_bounds,
    input  logic [PTR_W-1:0] slot,
    input  logic [VEC_W-1:0] vec,
    input  logic [PTR_W-1:0] ptr,
    input  logic [PTR_W-1:0] base,
    output logic             hit
);
    localparam int IDX_W = $clog2(VEC_W);

    logic slot_fits;
    logic vec_bit;

    always_comb begin
        slot_fits = slot < PTR_W'(VEC_W);
        vec_bit   = vec[slot[IDX_W-1:0]];
        unique case (mode)
            MODE_VECTOR:  hit = in_bounds && slot_fits && vec_bit;
            MODE_ALLONES: hit = in_bounds;
            MODE_EQUAL:   hit = ptr == base;
            default:      hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/call_target_checker.sv
module call_target_checker
    import cfc_pkg::*;
#(
    parameter int PTR_W   = 32,
    parameter int ALIGN_W = 4,
    parameter int SIZE_W  = 20,
    parameter int VEC_W   = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [PTR_W-1:0]   req_ptr,
    input  logic [PTR_W-1:0]   req_base,
    input  logic [ALIGN_W-1:0] req_align,
    input  logic [SIZE_W-1:0]  req_size,
    input  logic [VEC_W-1:0]   req_vec,
    input  logic [1:0]         req_mode,
    input  logic [PTR_W-1:0]   req_fail_tgt,
    output logic               rsp_valid,
    output logic               rsp_pass,
    output logic               rsp_trap,
    output logic [PTR_W-1:0]   rsp_redirect
);
    typedef struct packed {
        logic             valid;
        logic             pass;
        logic             trap;
        logic [PTR_W-1:0] redirect;
    } verdict_t;

    verdict_t         st_d, st_q;
    logic [PTR_W-1:0] slot;
    logic             in_bounds;
    logic             hit;
    logic             accept;

    cfc_bounds #(.PTR_W(PTR_W), .ALIGN_W(ALIGN_W), .SIZE_W(SIZE_W)) u_bounds (
        .ptr      (req_ptr),
        .base     (req_base),
        .align    (req_align),
        .size     (req_size),
        .slot     (slot),
        .in_bounds(in_bounds)
    );

    cfc_membership #(.PTR_W(PTR_W), .VEC_W(VEC_W)) u_member (
        .mode     (chk_mode_e'(req_mode)),
        .in_bounds(in_bounds),
        .slot     (slot),
        .vec      (req_vec),
        .ptr      (req_ptr),
        .base     (req_base),
        .hit      (hit)
    );

    assign req_ready = !st_q.valid;
    assign accept    = req_valid && req_ready;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (accept) begin
            st_d.valid = 1'b1;
            st_d.pass  = hit;
            st_d.trap  = !hit && (req_fail_tgt == '0);
            if (hit)
                st_d.redirect = req_ptr;
            else
                st_d.redirect = req_fail_tgt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid    = st_q.valid;
    assign rsp_pass     = st_q.pass;
    assign rsp_trap     = st_q.trap;
    assign rsp_redirect = st_q.redirect;

    // R2
    rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    // R2
    no_rsp_without_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid);
    // R2
    single_cycle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R9
    trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (!rsp_pass && rsp_redirect == '0));
    // R11
    pass_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!rsp_pass || rsp_redirect == $past(req_ptr)));
    // R8
    deny_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mode == 2'd3) |=> !rsp_pass);
    // R7
    equal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mode == 2'd2) |=> (rsp_pass == $past(req_ptr == req_base)));
    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> ($stable(rsp_pass) && $stable(rsp_trap) && $stable(rsp_redirect)));
endmodule

// File: tb/call_target_checker_tb.sv
module call_target_checker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_ptr = '0, req_base = '0, req_fail_tgt = '0;
    logic [3:0]  req_align = '0;
    logic [19:0] req_size = '0;
    logic [63:0] req_vec = '0;
    logic [1:0]  req_mode = '0;
    logic        rsp_valid, rsp_pass, rsp_trap;
    logic [31:0] rsp_redirect;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    call_target_checker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_ptr(req_ptr), .req_base(req_base), .req_align(req_align),
        .req_size(req_size), .req_vec(req_vec), .req_mode(req_mode),
        .req_fail_tgt(req_fail_tgt), .rsp_valid(rsp_valid), .rsp_pass(rsp_pass),
        .rsp_trap(rsp_trap), .rsp_redirect(rsp_redirect)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic model_pass(logic [31:0] p, logic [31:0] b, logic [3:0] a,
                                        logic [19:0] s, logic [63:0] v, logic [1:0] m);
        logic [63:0] span = {44'd0, s} << a;
        logic [31:0] off  = p - b;
        logic [31:0] mask = (32'd1 << a) - 32'd1;
        logic        inb  = (p >= b) && ({32'd0, off} < span) && ((off & mask) == 0);
        logic [31:0] idx  = off >> a;
        case (m)
            2'd0:    return inb && (idx < 64) && v[idx[5:0]];
            2'd1:    return inb;
            2'd2:    return p == b;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run(input string req, input logic [31:0] p, input logic [31:0] b,
                       input logic [3:0] a, input logic [19:0] s, input logic [63:0] v,
                       input logic [1:0] m, input logic [31:0] ft);
        logic ep;
        ep = model_pass(p, b, a, s, v, m);
        @(negedge clk);
        req_ptr = p; req_base = b; req_align = a; req_size = s;
        req_vec = v; req_mode = m; req_fail_tgt = ft; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " R2 rsp_valid"}, 64'(rsp_valid), 64'd1);
        check({req, " R2 ready low"}, 64'(req_ready), 64'd0);
        check({req, " pass"}, 64'(rsp_pass), 64'(ep));
        if (ep) begin
            check({req, " R11 trap"}, 64'(rsp_trap), 64'd0);
            check({req, " R11 redirect"}, 64'(rsp_redirect), 64'(p));
        end else if (ft == 0) begin
            check({req, " R9 trap"}, 64'(rsp_trap), 64'd1);
            check({req, " R9 redirect"}, 64'(rsp_redirect), 64'd0);
        end else begin
            check({req, " R10 trap"}, 64'(rsp_trap), 64'd0);
            check({req, " R10 redirect"}, 64'(rsp_redirect), 64'(ft));
        end
        @(negedge clk);
        check({req, " R2 single pulse"}, 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_reset();
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 pass", 64'(rsp_pass), 64'd0);
        check("R1 trap", 64'(rsp_trap), 64'd0);
        check("R1 redirect", 64'(rsp_redirect), 64'd0);
        check("R1 ready", 64'(req_ready), 64'd1);
    endtask

    task automatic t_bounds();
        run("R3 first slot", 32'h1000, 32'h1000, 4'd3, 20'd4, '0, 2'd1, 32'h0);
        run("R3 last slot", 32'h1018, 32'h1000, 4'd3, 20'd4, '0, 2'd1, 32'h0);
        run("R3 past end", 32'h1020, 32'h1000, 4'd3, 20'd4, '0, 2'd1, 32'h0);
        run("R3 below base", 32'h0FF8, 32'h1000, 4'd3, 20'd4, '0, 2'd1, 32'h0);
        run("R3 size zero", 32'h1000, 32'h1000, 4'd3, 20'd0, '0, 2'd1, 32'h0);
        run("R4 misaligned", 32'h1004, 32'h1000, 4'd3, 20'd4, '0, 2'd1, 32'h0);
        run("R4 misaligned low bit", 32'h1009, 32'h1000, 4'd3, 20'd4, '0, 2'd1, 32'h4000);
    endtask

    task automatic t_vector();
        run("R5 bit0 set", 32'h2000, 32'h2000, 4'd3, 20'd4, 64'h9, 2'd0, 32'h0);
        run("R5 bit1 clear", 32'h2008, 32'h2000, 4'd3, 20'd4, 64'h9, 2'd0, 32'h0);
        run("R5 bit3 set", 32'h2018, 32'h2000, 4'd3, 20'd4, 64'h9, 2'd0, 32'h0);
        run("R5 slot beyond vector", 32'h2000 + 70*4, 32'h2000, 4'd2, 20'd100, '1, 2'd0, 32'h8000);
        run("R5 slot 63", 32'h2000 + 63*4, 32'h2000, 4'd2, 20'd100, 64'h8000_0000_0000_0000, 2'd0, 32'h0);
        run("R6 vector ignored", 32'h2008, 32'h2000, 4'd3, 20'd4, 64'h0, 2'd1, 32'h0);
        run("R6 beyond vector ok", 32'h2000 + 70*4, 32'h2000, 4'd2, 20'd100, '0, 2'd1, 32'h0);
    endtask

    task automatic t_equal_deny();
        run("R7 equal match", 32'h3000, 32'h3000, 4'd7, 20'd0, '0, 2'd2, 32'h0);
        run("R7 equal miss", 32'h3008, 32'h3000, 4'd3, 20'd8, '1, 2'd2, 32'h5000);
        run("R8 deny", 32'h3000, 32'h3000, 4'd3, 20'd8, '1, 2'd3, 32'h0);
        run("R10 deny redirect", 32'h3000, 32'h3000, 4'd3, 20'd8, '1, 2'd3, 32'h6000);
    endtask

    task automatic t_hold();
        run("R12 setup", 32'h4010, 32'h4000, 4'd4, 20'd2, '0, 2'd1, 32'h0);
        req_ptr = 32'h0; req_mode = 2'd3; req_fail_tgt = 32'h7777;
        repeat (3) @(negedge clk);
        check("R12 pass held", 64'(rsp_pass), 64'd1);
        check("R12 trap held", 64'(rsp_trap), 64'd0);
        check("R12 redirect held", 64'(rsp_redirect), 64'h4010);
        check("R2 idle no rsp", 64'(rsp_valid), 64'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bounds();
        t_vector();
        t_equal_deny();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule